// File: doc/BRIEF.md
# Horizontal and Vertical Sync Rate Meter

This block measures the rates of a display's horizontal and vertical sync lines against the system clock. It takes clean, clock-synchronous H and V sync levels, and on each vertical window it reports two 12-bit period counts. Software turns these counts into line and field frequencies. The vertical count is the length of one V period, counted in units of 64 clocks. The horizontal count is the number of clocks spanned by eight consecutive H periods, which gives a resolution of one eighth of a clock per line.

A vertical window ends in one of two ways: a V rising edge arrives, or the vertical count would pass its 12-bit range. When the window ends, both counts are copied into byte-wide output registers and a one-cycle event pulse is raised. The copies then hold until the next event. If no V edge comes, the timeout keeps events coming, at a rate of Fosc/262144. If H stops, or runs slower than Fosc/512, the H count pins at its full-scale value.

Top module: `sync_freq_meter`

## Requirements
- R1: While reset is asserted, all four count bytes read 0 and the event output is 0.
- R2: When V rising edges are Q clocks apart, the V count latched at the second edge's event equals floor(Q/64), capped at 4095.
- R3: With H rising edges P clocks apart, the H count latched at an event equals 8*P. This is the clock count across the most recently completed run of eight H periods.
- R4: The H count reads 4095 when eight H periods span 4096 clocks or more, and also when H has no edges at all.
- R5: With no V rising edge, an event fires 4096*64 clocks after the window opened, the latched V count is 4095, and a new window starts at once.
- R6: Each V rising edge yields exactly one event pulse, one clock wide, in the cycle after the clock edge that first samples V high. A V level that stays high raises no further event.
- R7: Between events, all four count bytes hold their values.
- R8: Each low byte carries count bits [7:0]. Bits [3:0] of each high byte carry count bits [11:8]. Bits [7:4] of each high byte read 0, with bit 7 kept free for a polarity flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock (Fosc) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hsync_i | input | 1 | Clean horizontal sync level, synchronous to clk |
| vsync_i | input | 1 | Clean vertical sync level, synchronous to clk |
| h_lo_o | output | 8 | Latched H count bits [7:0] |
| h_hi_o | output | 8 | Latched H count bits [11:8] in [3:0]; [7:4] zero |
| v_lo_o | output | 8 | Latched V count bits [7:0] |
| v_hi_o | output | 8 | Latched V count bits [11:8] in [3:0]; [7:4] zero |
| evt_o | output | 1 | One-cycle pulse when new counts are latched |

## Verification
A prescaler or window counter that is off by one shows up as a V count that is wrong by one unit at the very next event. A faulty timeout shows up as a change in event spacing within one full 4096-unit window. A wrong H edge count or a bad saturation path corrupts the H byte pair at the first event after one complete eight-line window. A broken hold or pulse path shows up as byte changes or a wide pulse in the cycle after an event.

// File: rtl/sfm_pkg.sv
`timescale 1ns/1ps
package sfm_pkg;
  localparam int CNT_W  = 12;
  localparam int BYTE_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;
endpackage

// File: rtl/sfm_rise_det.sv
`timescale 1ns/1ps
module sfm_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
    rise_o = sig_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/sfm_hperiod.sv
`timescale 1ns/1ps
module sfm_hperiod
  import sfm_pkg::*;
#(
  parameter int PER_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output cnt_t meas_o
);
  localparam int EW = (PER_LOG2 > 0) ? PER_LOG2 : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'((1 << PER_LOG2) - 1);

  cnt_t run_q, run_d;
  cnt_t res_q, res_d;
  logic [EW-1:0] edg_q, edg_d;
  logic close_w;
  logic run_full;

  always_comb begin
    run_full = (run_q == CNT_MAX);
    close_w  = rise_i && (edg_q == LAST_EDGE);
    run_d    = close_w ? '0 : (run_full ? run_q : run_q + 1'b1);
    res_d    = res_q;
    if (close_w) res_d = run_full ? CNT_MAX : run_q + 1'b1;
    edg_d    = edg_q;
    if (rise_i) edg_d = close_w ? '0 : edg_q + 1'b1;
    meas_o   = run_full ? CNT_MAX : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      res_q <= CNT_MAX;
      edg_q <= '0;
    end else begin
      run_q <= run_d;
      res_q <= res_d;
      edg_q <= edg_d;
    end
  end
endmodule

// File: rtl/sfm_vwindow.sv
`timescale 1ns/1ps
module sfm_vwindow
  import sfm_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic close_o,
  output cnt_t meas_o
);
  localparam int PW = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

  logic [PW-1:0] pre_q, pre_d;
  cnt_t cnt_q, cnt_d;
  logic wrap;

  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign wrap = 1'b1;
    end else begin : g_div
      assign wrap = (pre_q == {PW{1'b1}});
    end
  endgenerate

  always_comb begin
    close_o = rise_i | ((cnt_q == CNT_MAX) & wrap);
    meas_o  = (wrap && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
    if (close_o) begin
      pre_d = '0;
      cnt_d = '0;
    end else begin
      pre_d = (DIV_LOG2 == 0) ? '0 : pre_q + 1'b1;
      cnt_d = wrap ? cnt_q + 1'b1 : cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sfm_outreg.sv
`timescale 1ns/1ps
module sfm_outreg
  import sfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  cnt_t              h_i,
  input  cnt_t              v_i,
  output logic [BYTE_W-1:0] h_lo_o,
  output logic [BYTE_W-1:0] h_hi_o,
  output logic [BYTE_W-1:0] v_lo_o,
  output logic [BYTE_W-1:0] v_hi_o,
  output logic              evt_o
);
  cnt_t h_q, h_d, v_q, v_d;
  logic evt_q, evt_d;

  always_comb begin
    h_d   = load_i ? h_i : h_q;
    v_d   = load_i ? v_i : v_q;
    evt_d = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      evt_q <= 1'b0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      evt_q <= evt_d;
    end
  end

  always_comb begin
    h_lo_o = h_q[BYTE_W-1:0];
    v_lo_o = v_q[BYTE_W-1:0];
    h_hi_o = BYTE_W'(h_q[CNT_W-1:BYTE_W]);
    v_hi_o = BYTE_W'(v_q[CNT_W-1:BYTE_W]);
    evt_o  = evt_q;
  end
endmodule

// File: rtl/sync_freq_meter.sv
`timescale 1ns/1ps
module sync_freq_meter
  import sfm_pkg::*;
#(
  parameter int H_PER_LOG2 = 3,
  parameter int V_DIV_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_i,
  input  logic       vsync_i,
  output logic [7:0] h_lo_o,
  output logic [7:0] h_hi_o,
  output logic [7:0] v_lo_o,
  output logic [7:0] v_hi_o,
  output logic       evt_o
);
  logic h_rise, v_rise, v_close;
  cnt_t h_meas, v_meas;

  sfm_rise_det u_hrise (.clk(clk), .rst_n(rst_n), .sig_i(hsync_i), .rise_o(h_rise));
  sfm_rise_det u_vrise (.clk(clk), .rst_n(rst_n), .sig_i(vsync_i), .rise_o(v_rise));

  sfm_hperiod #(.PER_LOG2(H_PER_LOG2)) u_hper (
    .clk(clk), .rst_n(rst_n), .rise_i(h_rise), .meas_o(h_meas)
  );

  sfm_vwindow #(.DIV_LOG2(V_DIV_LOG2)) u_vwin (
    .clk(clk), .rst_n(rst_n), .rise_i(v_rise), .close_o(v_close), .meas_o(v_meas)
  );

  sfm_outreg u_out (
    .clk(clk), .rst_n(rst_n), .load_i(v_close), .h_i(h_meas), .v_i(v_meas),
    .h_lo_o(h_lo_o), .h_hi_o(h_hi_o), .v_lo_o(v_lo_o), .v_hi_o(v_hi_o), .evt_o(evt_o)
  );
endmodule

// File: rtl/sync_freq_meter_chk.sv
`timescale 1ns/1ps
module sync_freq_meter_chk #(
  parameter int V_DIV_LOG2 = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync_i,
  input logic [7:0] h_lo_o,
  input logic [7:0] h_hi_o,
  input logic [7:0] v_lo_o,
  input logic [7:0] v_hi_o,
  input logic       evt_o
);
  localparam longint GAP_MAX = 64'd4096 << V_DIV_LOG2;
  longint gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap_q <= 0;
    else if (evt_o) gap_q <= 0;
    else            gap_q <= gap_q + 1;
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

  p_vedge_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_i) |=> evt_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_o |-> ($stable(h_lo_o) && $stable(h_hi_o) && $stable(v_lo_o) && $stable(v_hi_o)));

  p_hi_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_hi_o[7:4] == 4'd0) && (v_hi_o[7:4] == 4'd0));

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_MAX + 1);
endmodule

bind sync_freq_meter sync_freq_meter_chk #(.V_DIV_LOG2(V_DIV_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i),
  .h_lo_o(h_lo_o), .h_hi_o(h_hi_o), .v_lo_o(v_lo_o), .v_hi_o(v_hi_o), .evt_o(evt_o)
);

// File: tb/test_sync_freq_meter.sv
`timescale 1ns/1ps
module test_sync_freq_meter;
  logic clk = 1'b0;
  logic rst_n;
  logic hs, vs;
  logic [7:0] h_lo, h_hi, v_lo, v_hi;
  logic evt;
  logic [7:0] s_h_lo, s_h_hi, s_v_lo, s_v_hi;
  logic s_evt;
  logic zero_line;

  int checks = 0;
  int fails  = 0;

  localparam int NV = 5;
  // hsync period, vsync period, expected H, expected V
  localparam int VEC [NV][4] = '{
    '{32,  1000, 256,  15},
    '{100, 3000, 800,  46},
    '{511, 6400, 4088, 100},
    '{20,  2560, 160,  40},
    '{512, 4000, 4095, 62}
  };

  always #10 clk = ~clk;

  assign zero_line = 1'b0;

  sync_freq_meter i_sync_freq_meter (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs),
    .h_lo_o(h_lo), .h_hi_o(h_hi), .v_lo_o(v_lo), .v_hi_o(v_hi), .evt_o(evt)
  );

  sync_freq_meter #(.V_DIV_LOG2(0)) i_sync_freq_meter_sat (
    .clk(clk), .rst_n(rst_n), .hsync_i(zero_line), .vsync_i(zero_line),
    .h_lo_o(s_h_lo), .h_hi_o(s_h_hi), .v_lo_o(s_v_lo), .v_hi_o(s_v_hi), .evt_o(s_evt)
  );

  function automatic int cnt12(input logic [7:0] hi, input logic [7:0] lo);
    return int'({hi[3:0], lo});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int p, input int q, input int eh, input int ev);
    int seen = 0;
    bit prev = 1'b0;
    bit dbl = 1'b0;
    for (int cyc = 0; cyc < 4*q + 20 && seen < 4; cyc++) begin
      @(negedge clk);
      if (evt) begin
        seen++;
        if (seen == 4) begin
          chk(cnt12(h_hi, h_lo) == eh, (eh == 4095) ? "R4 H saturate" : "R3 H count",
              cnt12(h_hi, h_lo), eh);
          chk(cnt12(v_hi, v_lo) == ev, "R2 V count", cnt12(v_hi, v_lo), ev);
          chk(h_hi[7:4] == 0 && v_hi[7:4] == 0, "R8 high nibble zero",
              int'({h_hi[7:4], v_hi[7:4]}), 0);
        end
      end
      if (prev && evt) dbl = 1'b1;
      prev = evt;
      hs = (cyc % p) < 4;
      vs = (cyc % q) < 8;
    end
    chk(seen == 4, "R2 events per vector", seen, 4);
    chk(!dbl, "R6 single-cycle pulse", int'(dbl), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t_first, t_second;
    logic [7:0] snap [4];
    hs = 1'b0;
    vs = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({h_lo, h_hi, v_lo, v_hi} == 0 && !evt, "R1 reset outputs", int'(evt), 0);
    chk({s_h_lo, s_h_hi, s_v_lo, s_v_hi} == 0 && !s_evt, "R1 reset outputs sat", int'(s_evt), 0);
    rst_n = 1'b1;

    // R5 timeout spacing on the undivided instance: 4096 units
    t_first = -1;
    t_second = -1;
    for (int c = 0; c < 10000 && t_second < 0; c++) begin
      @(negedge clk);
      if (s_evt) begin
        if (t_first < 0) t_first = c;
        else t_second = c;
      end
    end
    chk(t_second - t_first == 4096, "R5 timeout spacing", t_second - t_first, 4096);
    chk(cnt12(s_v_hi, s_v_lo) == 4095, "R5 timeout V value", cnt12(s_v_hi, s_v_lo), 4095);
    chk(cnt12(s_h_hi, s_h_lo) == 4095, "R4 absent H", cnt12(s_h_hi, s_h_lo), 4095);
    chk(s_h_hi == 8'h0F && s_h_lo == 8'hFF, "R8 byte split", int'({s_h_hi, s_h_lo}), 16'h0FFF);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // R6 directed edge timing and no re-fire on held level
    vs = 1'b0;
    repeat (20) @(negedge clk);
    chk(!evt, "R6 quiet before edge", int'(evt), 0);
    vs = 1'b1;
    @(negedge clk);
    chk(evt, "R6 event after edge", int'(evt), 1);
    @(negedge clk);
    chk(!evt, "R6 pulse width", int'(evt), 0);
    snap[0] = h_lo; snap[1] = h_hi; snap[2] = v_lo; snap[3] = v_hi;
    begin
      bit refire = 1'b0;
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        if (evt) refire = 1'b1;
      end
      chk(!refire, "R6 held level no refire", int'(refire), 0);
    end
    // R7 hold between events
    chk(snap[0] == h_lo && snap[1] == h_hi && snap[2] == v_lo && snap[3] == v_hi,
        "R7 bytes hold", int'({h_hi, h_lo}), int'({snap[1], snap[0]}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule